// File: doc/BRIEF.md
# Bounded Bidirectional Address Counter

This block produces a run of consecutive addresses between two bounds. One example is sweeping a window of a frame buffer. A single-cycle start pulse captures a first address and a last address. From the next cycle on, the output shows the first address. It then moves one step per clock toward the last address and stops there by itself. The direction is chosen from the two bounds: it counts upward when the first address is less than or equal to the last, and downward otherwise.

The address state has one flip-flop per bit. The loaded value appears at the output on the cycle after start, with no extra staging cycle. A `busy` flag covers the whole run. A one-cycle `done` pulse marks the end of the run, and the address then holds the last value until the next run.

Top module: `addr_sweep`

## Requirements
- R1: A synchronous active-high `rst` sets `addr`, `busy` and `done` to zero on the next clock edge, including in the middle of a run.
- R2: A `start` sampled high while `busy` is low loads the bounds. After that edge, `addr` equals `first_addr`, `busy` is 1 and `done` is 0.
- R3: When `first_addr <= last_addr`, `addr` increases by exactly one on each clock edge after the load until it equals `last_addr`.
- R4: When `first_addr > last_addr`, `addr` decreases by exactly one on each clock edge after the load until it equals `last_addr`.
- R5: On the edge after the one that first put `last_addr` on `addr`, `done` rises and `busy` falls, and `addr` keeps the value `last_addr`.
- R6: `done` is high for exactly one cycle per run.
- R7: With equal bounds, `addr` shows that value for one cycle with `busy` high, and then `done` pulses.
- R8: A `start` sampled while `busy` is high is ignored: the current run continues with its original bounds and direction.
- R9: After a run completes, `addr` holds `last_addr` and `busy` stays low until a new `start` arrives.
- R10: With the default width of 4 bits (parameter `W`), runs from 0 to 15 and from 15 to 0 pass through all 16 values without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin a run |
| first_addr | input | W | Address at which the run begins |
| last_addr | input | W | Address at which the run ends |
| addr | output | W | Current address (registered) |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong direction bit would show up at the port one cycle after the load: `addr` would move away from `last_addr`. In that case `done` would only appear after a wrap, far later than the expected `|first-last|+1` cycles. A corrupted captured last address would show up as `done` arriving early or late against the cycle count, which follows directly from the two bounds. A load that is not gated by `busy` would show up on the edge after the stray `start` as a jump in `addr`. The bench covers all 256 pairs of bounds and checks every port on every cycle, so each of these faults is seen within a few cycles of the run in which it happens.

// File: rtl/addr_sweep_pkg.sv
package addr_sweep_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/addr_sweep_bounds.sv
module addr_sweep_bounds
  import addr_sweep_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] first_addr,
  input  logic [W-1:0] last_addr,
  output logic [W-1:0] end_q,
  output dir_e         dir_q
);
  // Direction is fixed once per run, from the two bounds at load time.
  always_ff @(posedge clk) begin
    if (rst) begin
      end_q <= '0;
      dir_q <= DIR_UP;
    end else if (load) begin
      end_q <= last_addr;
      dir_q <= (first_addr > last_addr) ? DIR_DOWN : DIR_UP;
    end
  end
endmodule

// File: rtl/addr_sweep_step.sv
module addr_sweep_step
  import addr_sweep_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         advance,
  input  dir_e         dir,
  input  logic [W-1:0] first_addr,
  input  logic [W-1:0] end_addr,
  output logic [W-1:0] addr_q,
  output logic         at_end
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // A single register per bit: the loaded value goes straight to the output.
  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (load)
      addr_q <= first_addr;
    else if (advance)
      addr_q <= (dir == DIR_DOWN) ? addr_q - ONE : addr_q + ONE;
  end

  assign at_end = (addr_q == end_addr);

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && dir == DIR_UP) |=> (addr_q == $past(addr_q) + ONE)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && dir == DIR_DOWN) |=> (addr_q == $past(addr_q) - ONE)); // R4
endmodule

// File: rtl/addr_sweep_ctrl.sv
module addr_sweep_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic at_end,
  output logic load,
  output logic advance,
  output logic busy_q,
  output logic done_q
);
  assign load    = start && !busy_q;
  assign advance = busy_q && !at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && at_end;
      if (load)
        busy_q <= 1'b1;
      else if (busy_q && at_end)
        busy_q <= 1'b0;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R5
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy_q && !done_q)); // R2
endmodule

// File: rtl/addr_sweep.sv
module addr_sweep
  import addr_sweep_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] first_addr,
  input  logic [W-1:0] last_addr,
  output logic [W-1:0] addr,
  output logic         busy,
  output logic         done
);
  logic         load;
  logic         advance;
  logic         at_end;
  logic [W-1:0] end_q;
  dir_e         dir_q;

  addr_sweep_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .at_end  (at_end),
    .load    (load),
    .advance (advance),
    .busy_q  (busy),
    .done_q  (done)
  );

  addr_sweep_bounds #(.W(W)) u_bounds (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .first_addr (first_addr),
    .last_addr  (last_addr),
    .end_q      (end_q),
    .dir_q      (dir_q)
  );

  addr_sweep_step #(.W(W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .advance    (advance),
    .dir        (dir_q),
    .first_addr (first_addr),
    .end_addr   (end_q),
    .addr_q     (addr),
    .at_end     (at_end)
  );

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(end_q) && $stable(dir_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(addr) && !busy)); // R9
endmodule

// File: tb/addr_sweep_bench.sv
`timescale 1ns/1ps
module addr_sweep_bench;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] sa = '0;
  logic [W-1:0] sb = '0;
  logic [W-1:0] addr;
  logic         busy;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  addr_sweep #(.W(W)) u_addr_sweep (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .first_addr (sa),
    .last_addr  (sb),
    .addr       (addr),
    .busy       (busy),
    .done       (done)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  // One complete run; poke_at > 0 injects a start while busy before that step.
  task automatic run(input int s, input int e, input int poke_at);
    int n = (s > e) ? s - e : e - s;
    int d = (s > e) ? -1 : 1;
    string rq = (s == e) ? "R7" : ((s > e) ? "R4" : "R3");
    if ((s == 0 && e == MAXV) || (s == MAXV && e == 0)) rq = "R10";
    @(negedge clk);
    start = 1'b1; sa = W'(s); sb = W'(e);
    @(negedge clk);
    start = 1'b0; sa = W'(MAXV - s); sb = W'(s);
    chk(addr, s, "R2 addr");
    chk(busy, 1, "R2 busy");
    chk(done, 0, "R2 done");
    for (int j = 1; j <= n; j++) begin
      if (j == poke_at) begin
        start = 1'b1; sa = W'(e); sb = W'(s);
      end
      @(negedge clk);
      start = 1'b0;
      chk(addr, s + d * j, (j == poke_at) ? "R8 addr" : rq);
      chk(busy, 1, (j == poke_at) ? "R8 busy" : rq);
      chk(done, 0, rq);
    end
    @(negedge clk);
    chk(done, 1, (s == e) ? "R7 done" : "R5 done");
    chk(busy, 0, "R5 busy");
    chk(addr, e, "R5 addr");
    @(negedge clk);
    chk(done, 0, "R6 done");
    chk(addr, e, "R9 addr");
    chk(busy, 0, "R9 busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(addr, 0, "R1 addr");
    chk(busy, 0, "R1 busy");
    chk(done, 0, "R1 done");
    rst = 1'b0;

    for (int s = 0; s <= MAXV; s++)
      for (int e = 0; e <= MAXV; e++)
        run(s, e, 0);

    run(3, 12, 4);
    run(14, 1, 6);
    run(0, MAXV, 1);

    // idle hold over several cycles with changing bound inputs
    sa = 4'd9; sb = 4'd2;
    repeat (5) @(negedge clk);
    chk(addr, MAXV, "R9 hold");
    chk(busy, 0, "R9 hold busy");

    // reset during a run
    @(negedge clk);
    start = 1'b1; sa = 4'd2; sb = 4'd11;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(addr, 0, "R1 mid addr");
    chk(busy, 0, "R1 mid busy");
    chk(done, 0, "R1 mid done");
    rst = 1'b0;
    run(5, 5, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule